// File: doc/BRIEF.md
# Interval and Watchdog Timer

The block is an 8-bit up-counter that advances on count-enable pulses taken from one of eight taps of a free-running system-clock divider. A control/status byte selects the tap, starts or stops the counter and picks one of two behaviours on counter overflow. In interval mode an overflow latches a flag, and the flag drives a level interrupt request. In watchdog mode an overflow can instead raise a one-cycle internal reset request. Whether it does depends on a reset-enable input.

Software reaches the block through a small read/write port with two addresses: address 0 holds the control/status byte and address 1 holds the counter. Writes to the control/status byte are guarded by a key. A 16-bit write takes effect only when its upper byte holds the key value 0xA5, and the lower byte then carries the new contents. The overflow flag can only be cleared in two steps: software reads the byte while the flag is set, then makes an accepted write with a 0 in the flag bit.

Top module: `wdog_itimer`

## Requirements
- R1: After reset the counter reads 0x00, the control/status byte reads 0x18, and both the interrupt and the reset request are low.
- R2: While enabled, the counter increases by one on each divider tick. The divider is a 17-bit count of system clock cycles since reset. A tick is a cycle in which its low k bits are all ones. The clock select code picks k as follows: 000 gives 1, 001 gives 6, 010 gives 7, 011 gives 9, 100 gives 11, 101 gives 13, 110 gives 15 and 111 gives 17.
- R3: While the enable bit (bit 5) is 0, the counter is held at 0x00.
- R4: The control/status byte has this layout: bit 7 is the overflow flag, bit 6 is the mode (1 for watchdog), bit 5 is the enable, bits 4:3 always read 1, and bits 2:0 are the clock select. A write to address 0 changes the byte only when the upper data byte is 0xA5. Writes with any other key are ignored.
- R5: When an enabled counter steps from 0xFF to 0x00, the overflow flag is set, except in the case given in R8.
- R6: An accepted write with bit 7 = 0 clears the flag only if a read of address 0 (read strobe high) saw the flag at 1 after the previous accepted write. Writing 1 to bit 7 has no effect on the flag, and so does writing 0 with no prior read.
- R7: The interrupt output is high exactly while the flag is set and the mode bit is 0.
- R8: In watchdog mode with the reset-enable input high, an overflow produces a reset request pulse of exactly one cycle and leaves the flag at 0. With reset-enable low, the overflow sets the flag, gives no pulse and gives no interrupt.
- R9: A read of address 1 returns the counter. Writes to address 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | Write address: 0 for control/status, 1 for counter |
| wr_data_i | input | 16 | Upper byte is the key, lower byte is the data |
| rd_en_i | input | 1 | Read strobe, used to arm the flag clear |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data for rd_addr_i, combinational |
| rst_en_i | input | 1 | Allows overflow in watchdog mode to request a reset |
| irq_o | output | 1 | Interval interrupt request, level |
| rst_req_o | output | 1 | Internal reset request, one-cycle pulse |

## Verification
The assertions assume that the write and read strobes and addresses are synchronous to the clock and stable around the rising edge. They also assume that reset-enable changes only between edges. The bench drives every input on the falling edge, so each strobe lasts exactly one cycle. Flag-clear checks are placed well within a 512-cycle overflow period, so that no overflow lands on the same edge as the clearing write. Arbitrary key values and writes to the counter address are included on purpose, because they must leave state untouched.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Number of low divider bits that must all be one for a tick.
    function automatic int unsigned tap_len(input logic [2:0] sel);
        case (sel)
            3'd0:    tap_len = 1;
            3'd1:    tap_len = 6;
            3'd2:    tap_len = 7;
            3'd3:    tap_len = 9;
            3'd4:    tap_len = 11;
            3'd5:    tap_len = 13;
            3'd6:    tap_len = 15;
            default: tap_len = 17;
        endcase
    endfunction

    typedef struct packed {
        logic       flag;
        logic       wd;
        logic       en;
        logic [2:0] cks;
        logic       arm;
        logic       rst_req;
    } ctrl_t;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV_W = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    import wdog_pkg::*;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (i < tap_len(sel_i));
    end

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick_o = ((div_q & mask) == mask);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)       cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = en_i && tick_i && (&cnt_q);
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer #(
    parameter int          CNT_W = 8,
    parameter int          DIV_W = 17,
    parameter logic [7:0]  KEY   = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               wr_addr_i,
    input  logic [2*CNT_W-1:0] wr_data_i,
    input  logic               rd_en_i,
    input  logic               rd_addr_i,
    output logic [CNT_W-1:0]   rd_data_o,
    input  logic               rst_en_i,
    output logic               irq_o,
    output logic               rst_req_o
);
    import wdog_pkg::*;

    localparam int BUS_W = 2 * CNT_W;

    ctrl_t            s_d, s_q;
    logic             tick, ovf, key_wr;
    logic [CNT_W-1:0] cnt;
    logic             flag_q, wd_q, en_q;
    logic             unused_rsvd;

    assign unused_rsvd = ^wr_data_i[4:3];

    wdog_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (s_q.cks),
        .tick_o (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (s_q.en),
        .tick_i (tick),
        .cnt_o  (cnt),
        .ovf_o  (ovf)
    );

    assign key_wr = wr_en_i && !wr_addr_i && (wr_data_i[BUS_W-1:CNT_W] == KEY);

    always_comb begin
        s_d         = s_q;
        s_d.rst_req = 1'b0;
        if (rd_en_i && !rd_addr_i && s_q.flag) s_d.arm = 1'b1;
        if (key_wr) begin
            s_d.wd  = wr_data_i[6];
            s_d.en  = wr_data_i[5];
            s_d.cks = wr_data_i[2:0];
            if (!wr_data_i[7] && s_q.arm) s_d.flag = 1'b0;
            s_d.arm = 1'b0;
        end
        if (ovf) begin
            if (s_q.wd && rst_en_i) begin
                s_d.flag    = 1'b0;
                s_d.arm     = 1'b0;
                s_d.rst_req = 1'b1;
            end else begin
                s_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_q    = s_q.flag;
    assign wd_q      = s_q.wd;
    assign en_q      = s_q.en;
    assign rd_data_o = rd_addr_i ? cnt : {s_q.flag, s_q.wd, s_q.en, 2'b11, s_q.cks};
    assign irq_o     = s_q.flag && !s_q.wd;
    assign rst_req_o = s_q.rst_req;
endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk #(
    parameter int         CNT_W = 8,
    parameter logic [7:0] KEY   = 8'hA5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en_i,
    input logic               wr_addr_i,
    input logic [2*CNT_W-1:0] wr_data_i,
    input logic               rd_addr_i,
    input logic [CNT_W-1:0]   rd_data_o,
    input logic               rst_en_i,
    input logic               rst_req_o,
    input logic               tick,
    input logic               ovf,
    input logic [CNT_W-1:0]   cnt,
    input logic               flag_q,
    input logic               wd_q,
    input logic               en_q
);
    logic good_wr;
    assign good_wr = wr_en_i && !wr_addr_i && (wr_data_i[2*CNT_W-1:CNT_W] == KEY);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> cnt == '0);  // R3
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && !tick |=> $stable(cnt));  // R2
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !(wd_q && rst_en_i) |=> flag_q);  // R5
    AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> rst_req_o || $past(good_wr && !wr_data_i[7]));  // R6
    AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_addr_i |-> rd_data_o[4:3] == 2'b11);  // R4
    AST_RST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);  // R8
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(wd_q && rst_en_i && ovf));  // R8
endmodule

bind wdog_itimer wdog_itimer_chk #(.CNT_W(CNT_W), .KEY(KEY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .rst_en_i  (rst_en_i),
    .rst_req_o (rst_req_o),
    .tick      (tick),
    .ovf       (ovf),
    .cnt       (cnt),
    .flag_q    (flag_q),
    .wd_q      (wd_q),
    .en_q      (en_q)
);

// File: tb/wdog_itimer_tb.sv
`timescale 1ns/1ps
module wdog_itimer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_addr = 1'b0, rst_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq, rst_req;

    int checks = 0, fails = 0, pulses = 0;

    always #10 clk = ~clk;

    wdog_itimer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .rst_en_i(rst_en), .irq_o(irq), .rst_req_o(rst_req)
    );

    // Behavioural reference model
    int   m_div, m_cnt;
    bit   m_flag, m_wd, m_en, m_arm, m_rst;
    bit [2:0] m_cks;

    function automatic int klen(input bit [2:0] c);
        int t[8] = '{1, 6, 7, 9, 11, 13, 15, 17};
        return t[c];
    endfunction

    function automatic bit [7:0] m_csr();
        return {m_flag, m_wd, m_en, 2'b11, m_cks};
    endfunction

    task automatic check(input bit [7:0] act, input bit [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_flag = 0; m_wd = 0; m_en = 0;
            m_arm = 0; m_rst = 0; m_cks = 0;
        end else begin
            bit tk, of, nflag, nwd, nen, narm, nrst;
            bit [2:0] ncks;
            int ncnt;
            tk = ((m_div + 1) % (1 << klen(m_cks))) == 0;
            of = m_en && tk && m_cnt == 255;
            ncnt = !m_en ? 0 : (tk ? (m_cnt + 1) % 256 : m_cnt);
            nflag = m_flag; nwd = m_wd; nen = m_en; ncks = m_cks; narm = m_arm; nrst = 0;
            if (rd_en && !rd_addr && m_flag) narm = 1;
            if (wr_en && !wr_addr && wr_data[15:8] == 8'hA5) begin
                nwd = wr_data[6]; nen = wr_data[5]; ncks = wr_data[2:0];
                if (!wr_data[7] && m_arm) nflag = 0;
                narm = 0;
            end
            if (of) begin
                if (m_wd && rst_en) begin nflag = 0; narm = 0; nrst = 1; end
                else nflag = 1;
            end
            m_div = (m_div + 1) % (1 << 17);
            m_cnt = ncnt; m_flag = nflag; m_wd = nwd; m_en = nen; m_cks = ncks;
            m_arm = narm; m_rst = nrst;
        end
        #2;
        check({7'd0, irq}, {7'd0, m_flag && !m_wd}, "R7");
        check({7'd0, rst_req}, {7'd0, m_rst}, "R8");
        if (rd_addr) check(rd_data, m_cnt[7:0], "R9");
        else         check(rd_data, m_csr(), "R4");
        if (rst_req) pulses++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic csr_wr(input bit [15:0] d);
        @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic csr_rd();
        @(negedge clk); rd_en = 1; rd_addr = 0;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic peek(input bit a, output bit [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        bit [7:0] v;
        int p0;
        cyc(3);
        peek(0, v); check(v, 8'h18, "R1");
        peek(1, v); check(v, 8'h00, "R1");
        check({6'd0, irq, rst_req}, 8'h00, "R1");
        rst_n = 1;
        cyc(2);

        csr_wr(16'h5A20);
        peek(0, v); check(v, 8'h18, "R4 bad key");
        cyc(10); peek(1, v); check(v, 8'h00, "R3 still disabled");

        csr_wr(16'hA520);
        cyc(600);
        peek(0, v); check(v[7], 1'b1, "R5 flag after overflow");
        check({7'd0, irq}, 8'h01, "R7 irq in interval mode");

        csr_wr(16'hA520);
        peek(0, v); check(v[7], 1'b1, "R6 no clear without read");
        csr_rd(); csr_wr(16'hA5A0);
        peek(0, v); check(v[7], 1'b1, "R6 write 1 no effect");
        csr_rd(); csr_wr(16'hA520);
        peek(0, v); check(v[7], 1'b0, "R6 read then write 0 clears");
        check({7'd0, irq}, 8'h00, "R7 irq low after clear");

        csr_wr(16'hA500);
        cyc(3); peek(1, v); check(v, 8'h00, "R3 disabled counter held");

        for (int c = 1; c < 5; c++) begin
            csr_wr(16'hA520 | 16'(c));
            cyc(300 + 40 * c);
            peek(1, v); check(v, m_cnt[7:0], "R2 count vs divider tap");
            csr_wr(16'hA500);
        end

        wr_en = 0;
        @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 16'hA5FF;
        @(negedge clk); wr_en = 0;
        peek(0, v); check(v, 8'h18, "R9 write to counter address ignored");

        rst_en = 1;
        p0 = pulses;
        csr_wr(16'hA560);
        cyc(600);
        check(8'(pulses - p0), 8'd1, "R8 single reset pulse");
        peek(0, v); check(v[7], 1'b0, "R8 flag left clear");

        rst_en = 0;
        p0 = pulses;
        cyc(520);
        peek(0, v); check(v[7], 1'b1, "R8 flag set without reset enable");
        check(8'(pulses - p0), 8'd0, "R8 no pulse without reset enable");
        check({7'd0, irq}, 8'h00, "R8 no irq in watchdog mode");

        cyc(5);
        finish_run();
    end
endmodule